// File: doc/BRIEF.md
# I2C Target with Busy-Withheld Acknowledge

This block is the bus-facing front end of an I2C target device. It watches SCL and SDA, which arrive already synchronized to a fast system clock. It recognizes START, repeated START and STOP, and collects the 7-bit target address and the direction bit. It then exchanges bytes with an attached byte-wide store through a simple local port. SDA is open-drain: the block asserts `sda_oe` to pull the line low and otherwise leaves it released.

In a write transfer, the first data byte sets an internal pointer. Each later byte is written at the pointer, and the pointer then advances. In a read transfer, the target returns the byte at the pointer, advances the pointer and continues for as long as the master acknowledges.

The attached store may report that an internal programming cycle is running. While it does, the target acknowledges nothing, and that includes its own address. A master can therefore keep polling the address until it gets an acknowledge, which tells it the store is ready.

Top module: `i2c_busy_target`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sda_oe` and `mem_we` are 0. After reset, `mem_addr` is 0.
- R2: An address byte whose upper 7 bits equal `OWN_ADDR` is acknowledged when `mem_busy` is low. Acknowledge means SDA is held low for the whole high phase of the ninth clock.
- R3: When the address does not match, the target never pulls SDA low. It neither writes nor moves the pointer until the next START.
- R4: When `mem_busy` is high at the end of a byte, that byte gets no acknowledge. This applies to the address byte and to write data bytes. A data byte received while busy is not written, and the target ignores the bus until the next START.
- R5: In a write transfer, the first data byte loads the pointer with its low `PTR_W` bits. Each later data byte produces one single-cycle `mem_we` pulse, with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte. The pointer then increments.
- R6: In a read transfer, the target sends the byte stored at the pointer, MSB first, starting right after the address acknowledge. The pointer increments for each byte loaded. After a master ACK (SDA low on the ninth clock), the next byte follows.
- R7: After a master NACK (SDA high on the ninth clock), the target releases SDA. It does not drive it again until the next START.
- R8: `sda_oe` changes only while SCL is low. It changes at least one system clock after the falling edge of SCL.
- R9: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) aborts any byte in progress. A START restarts address reception. A STOP returns the target to idle with SDA released.
- R10: The number of bytes in a transfer is unlimited. The pointer wraps modulo 2^`PTR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired line) |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_busy | input | 1 | Store is in an internal programming cycle |
| mem_addr | output | PTR_W | Local pointer, byte address into the store |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Byte stored at `mem_addr` (combinational read) |

## Verification
The bench builds the target with `PTR_W` = 4 and `OWN_ADDR` = 7'h50, so the attached store has 16 bytes. This size lets the bench sweep all 128 addresses with busy both low and high. It also writes from every one of the 16 pointer starts, with pointer bytes whose upper bits are set so that truncation is exercised. A single read of 20 bytes runs past the end of the store and wraps the pointer. Aborted bytes, busy during a data byte, and the quiet bus after a NACK are each driven explicitly. All expected bytes come from a model of the store that the bench keeps itself.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
        return b[7:1] == own;
    endfunction

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.scl_rise = scl_i & ~scl_q;
        evt.scl_fall = ~scl_i & scl_q;
        evt.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_ptr.sv
module i2c_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/i2c_busy_target.sv
module i2c_busy_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h50,
    parameter int         PTR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             mem_busy,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    input  logic [7:0]       mem_rdata
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

    bus_evt_t         evt;
    tgt_state_e       st;
    logic [7:0]       rx, tx, wdata_q;
    logic [CNT_W-1:0] bitc;
    logic             rw, first, mack;
    logic             we_q, ld_q, rd_inc_q;
    logic [2:0]       rd_idx;

    i2c_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_q),
        .load_val (PTR_W'(wdata_q)),
        .inc      (we_q | rd_inc_q),
        .ptr      (mem_addr)
    );

    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;
    assign rd_idx    = 3'd7 - bitc[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rx       <= '0;
            tx       <= '0;
            wdata_q  <= '0;
            bitc     <= '0;
            rw       <= 1'b0;
            first    <= 1'b0;
            mack     <= 1'b0;
            we_q     <= 1'b0;
            ld_q     <= 1'b0;
            rd_inc_q <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            we_q     <= 1'b0;
            ld_q     <= 1'b0;
            rd_inc_q <= 1'b0;
            if (evt.start) begin
                st     <= ST_ADDR;
                bitc   <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                bitc   <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WR: begin
                        if (evt.scl_rise) begin
                            rx   <= {rx[6:0], sda_i};
                            bitc <= bitc + 1'b1;
                        end else if (evt.scl_fall && bitc == BYTE_BITS) begin
                            if (mem_busy) begin
                                st <= ST_SKIP;
                            end else if (st == ST_ADDR) begin
                                if (addr_hit(rx, OWN_ADDR)) begin
                                    st     <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                    rw     <= rx[0];
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                st      <= ST_WR_ACK;
                                sda_oe  <= 1'b1;
                                wdata_q <= rx;
                                if (first) begin
                                    ld_q  <= 1'b1;
                                    first <= 1'b0;
                                end else begin
                                    we_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitc <= '0;
                            if (rw) begin
                                st       <= ST_RD;
                                tx       <= mem_rdata;
                                rd_inc_q <= 1'b1;
                                sda_oe   <= ~mem_rdata[7];
                            end else begin
                                st     <= ST_WR;
                                first  <= 1'b1;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            st     <= ST_WR;
                            bitc   <= '0;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (evt.scl_rise) begin
                            bitc <= bitc + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitc == BYTE_BITS) begin
                                st     <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                            end else if (bitc != '0) begin
                                sda_oe <= ~tx[rd_idx];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~sda_i;
                        end else if (evt.scl_fall) begin
                            bitc <= '0;
                            if (mack) begin
                                st       <= ST_RD;
                                tx       <= mem_rdata;
                                rd_inc_q <= 1'b1;
                                sda_oe   <= ~mem_rdata[7];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_busy_target_chk.sv
module i2c_busy_target_chk
    import i2c_tgt_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     scl_i,
    input logic     mem_busy,
    input logic     sda_oe,
    input logic     mem_we,
    input bus_evt_t evt,
    input logic     addr_ack
);
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !mem_we));

    p_ack_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_ack) |-> !$past(mem_busy));

    p_no_write_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !$past(mem_busy));

    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_i));

    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);
endmodule

bind i2c_busy_target i2c_busy_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .mem_busy (mem_busy),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .evt      (evt),
    .addr_ack (st == i2c_tgt_pkg::ST_ADDR_ACK)
);

// File: tb/tb_i2c_busy_target.sv
module tb_i2c_busy_target;
    localparam int         PTR_W = 4;
    localparam int         DEPTH = 1 << PTR_W;
    localparam logic [6:0] OWN   = 7'h50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, mem_we;
    logic [PTR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    int n_chk = 0;
    int n_bad = 0;
    int oe_hi_changes = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    i2c_busy_target #(.OWN_ADDR(OWN), .PTR_W(PTR_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_busy  (busy),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // R8 monitor: output enable must never move across a high SCL phase
    always @(negedge clk) begin
        if (!rst && sda_oe != oe_prev && scl && scl_prev) oe_hi_changes++;
        oe_prev  = sda_oe;
        scl_prev = scl;
    end

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tick(2); sda_m = b;
        tick(2); scl = 1'b1;
        tick(2); seen = sda_line;
        tick(2); scl = 1'b0;
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(2);
        scl = 1'b1; tick(3);
        sda_m = 1'b0; tick(3);
        scl = 1'b0; tick(1);
    endtask

    task automatic do_stop();
        tick(2); sda_m = 1'b0;
        tick(2); scl = 1'b1;
        tick(3); sda_m = 1'b1;
        tick(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        logic s;
        for (int i = 7; i > 7 - nbits; i--) bit_io(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        send_bits(b, 8);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(~master_ack, s);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [PTR_W-1:0] p;
        logic [7:0] v;
        logic quiet;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 8'(i * 3 + 1);
            exp_mem[i] = 8'(i * 3 + 1);
        end
        tick(3);
        check(!sda_oe && !mem_we, "R1 during reset", {sda_oe, mem_we}, 0);
        rst = 1'b0;
        tick(1);
        check(!sda_oe && !mem_we && mem_addr == '0, "R1 after reset",
              {sda_oe, mem_we, mem_addr}, 0);

        // R2 / R3 / R4: every address, busy low and high
        for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < 128; a++) begin
                busy = (b == 1);
                do_start();
                send_byte({7'(a), 1'b0}, ack);
                check(ack == (a == int'(OWN) && b == 0),
                      (a == int'(OWN)) ? ((b == 1) ? "R4 busy address" : "R2 address ack")
                                       : "R3 foreign address", ack, (a == int'(OWN) && b == 0));
                do_stop();
            end
        end
        busy = 1'b0;

        // R3: traffic to another address has no effect
        do_start();
        send_byte({OWN ^ 7'h01, 1'b0}, ack);
        send_byte(8'h03, ack);
        check(!ack, "R3 no ack after foreign address", ack, 0);
        send_byte(8'hEE, ack);
        do_stop();
        check(mem[3] == exp_mem[3] && mem_addr == '0, "R3 store untouched",
              {mem[3], 4'(mem_addr)}, {exp_mem[3], 4'h0});

        // R5 / R10: writes from every pointer start, upper pointer bits set
        for (int ps = 0; ps < DEPTH; ps++) begin
            do_start();
            send_byte({OWN, 1'b0}, ack);
            send_byte(8'hA0 | 8'(ps), ack);
            check(ack, "R5 pointer byte ack", ack, 1);
            for (int k = 0; k < 3; k++) begin
                v = 8'((ps * 37 + k * 11) ^ 8'h5A);
                send_byte(v, ack);
                check(ack, "R5 data ack", ack, 1);
                p = PTR_W'(ps + k);
                exp_mem[p] = v;
            end
            do_stop();
            check(mem_addr == PTR_W'(ps + 3), "R10 pointer after write",
                  mem_addr, PTR_W'(ps + 3));
        end
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] == exp_mem[i], "R5 store content", mem[i], exp_mem[i]);

        // R6 / R10 / R7: pointer set, repeated START, long read with wrap
        do_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'd13, ack);
        do_start();
        send_byte({OWN, 1'b1}, ack);
        check(ack, "R6 read address ack", ack, 1);
        for (int i = 0; i < 20; i++) begin
            read_byte(i != 19, d);
            p = PTR_W'(13 + i);
            check(d == exp_mem[p], "R6 read byte", d, exp_mem[p]);
        end
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            logic s;
            bit_io(1'b1, s);
            quiet &= s;
        end
        check(quiet, "R7 released after NACK", quiet, 1);
        do_stop();

        // R4: busy during a write data byte
        do_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'd2, ack);
        busy = 1'b1;
        send_byte(8'h77, ack);
        check(!ack, "R4 busy data no ack", ack, 0);
        busy = 1'b0;
        send_byte(8'h66, ack);
        check(!ack, "R4 ignored until START", ack, 0);
        do_stop();
        check(mem[2] == exp_mem[2] && mem[3] == exp_mem[3], "R4 no write while busy",
              mem[2], exp_mem[2]);

        // R9: aborted address, then aborted data byte
        do_start();
        send_bits({OWN, 1'b0}, 4);
        do_start();
        send_byte({OWN, 1'b0}, ack);
        check(ack, "R9 address after repeated START", ack, 1);
        send_byte(8'd6, ack);
        send_byte(8'h3C, ack);
        exp_mem[6] = 8'h3C;
        send_bits(8'h00, 3);
        do_stop();
        check(mem[6] == 8'h3C && mem[7] == exp_mem[7], "R9 partial byte dropped",
              mem[7], exp_mem[7]);
        check(mem_addr == PTR_W'(7), "R9 pointer after abort", mem_addr, 7);
        check(!sda_oe, "R9 idle after STOP", sda_oe, 0);
        do_start();
        send_byte({OWN, 1'b1}, ack);
        read_byte(1'b0, d);
        check(d == exp_mem[7], "R9 read after STOP", d, exp_mem[7]);
        do_stop();

        check(oe_hi_changes == 0, "R8 oe change while SCL high", oe_hi_changes, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule